// File: doc/BRIEF.md
# DDR DRAM power-up initialization sequencer

This block owns the command bus of a four-bank double-data-rate DRAM from reset until the device can take normal traffic. It holds the clock enable low and the bus deselected until the board reports that the supplies and the clock are steady. It then waits a fixed power-up interval. After that it walks the device through its mandatory bring-up commands, placing idle (NOP) cycles between them, and raises a done flag. At that point a normal memory controller takes over the bus.

The operating mode word and the extended mode word come in as inputs, so the same sequencer serves any burst length or latency setting. Every timing figure is a parameter. The power-up interval is expressed in nanoseconds and turned into a cycle count from the clock period. The gaps after precharge, after mode programming and after refresh are given in cycles, and so is the lock-up interval that must follow the DLL reset.

Top module: `ddr_init_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mem_cke` is 0, the strobes {cs_n, ras_n, cas_n, we_n} read 1111, `mem_ba` and `mem_addr` are 0 and `init_done` is 0.
- R2: `mem_cke` stays 0 and the strobes stay at 1111 until `pwr_stable` has been high for PWR_WAIT_CYC consecutive cycles. If `pwr_stable` drops, that count starts over. CKE rises no more than two cycles after the count is met.
- R3: In the cycle that `mem_cke` first goes high, the bus carries a NOP, which is strobes 0111.
- R4: After that NOP the block issues exactly seven commands, in this order: precharge-all, extended mode set, mode set with DLL reset, precharge-all, refresh, refresh, mode set without DLL reset. Every other cycle in between is a NOP.
- R5: A precharge-all is strobes 0010 with `mem_addr[10]` = 1, all other address bits 0 and `mem_ba` = 00.
- R6: The extended mode set is strobes 0000 with `mem_ba` = 01 and `mem_addr` equal to `emr_value`.
- R7: Both base mode sets are strobes 0000 with `mem_ba` = 00. The first one carries `mr_value` with bit 8 forced to 1. The last one carries `mr_value` with bit 8 forced to 0.
- R8: A refresh is strobes 0001 with `mem_ba` = 00 and `mem_addr` = 0.
- R9: Following each command there are at least T_RP NOP cycles after a precharge, T_MRD after a mode set, and T_RFC after a refresh.
- R10: `init_done` rises at least DLL_LOCK_CYC cycles after the DLL-reset mode set, and within four cycles of that bound when the other gaps are shorter. It also rises only after the final mode set and its T_MRD gap. Once high, it stays high with NOPs on the bus until reset.
- R11: A synchronous reset at any point, including partway through the command run, returns the block to the R1 state. The whole sequence then restarts from the power-up wait, using the mode words present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_stable | input | 1 | Supplies and clock reported stable |
| mr_value | input | ADDR_W | Operating parameters for the base mode register |
| emr_value | input | ADDR_W | Value for the extended mode register (DLL enable) |
| mem_cke | output | 1 | DRAM clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Bring-up complete, bus may be handed over |

## Verification
The hardest case to reach from the ports is a reset that lands partway through the command run. The DLL lock counter must be thrown away along with the step index, and the rerun must pick up the new mode words. To reach it, the bench watches the live command trace, pulses reset once the third command has gone out, changes both mode words and replays the full run. A second case is a stability flag that drops partway through the power-up wait. It is produced by lowering `pwr_stable` for two cycles halfway through, and the bench measures CKE against the last rising edge of the flag.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_ISSUE,
    ST_GAP,
    ST_LOCK,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    K_NOP,
    K_PREA,
    K_EMRS,
    K_MRS_RST,
    K_REF,
    K_MRS_RUN
  } step_kind_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] BUS_DESEL = 4'b1111;
  localparam logic [3:0] BUS_NOP   = 4'b0111;
  localparam logic [3:0] BUS_PRE   = 4'b0010;
  localparam logic [3:0] BUS_REF   = 4'b0001;
  localparam logic [3:0] BUS_MRS   = 4'b0000;

  localparam logic [2:0] LAST_STEP = 3'd7;

  function automatic step_kind_e step_kind(input logic [2:0] idx);
    case (idx)
      3'd0:    return K_NOP;
      3'd1:    return K_PREA;
      3'd2:    return K_EMRS;
      3'd3:    return K_MRS_RST;
      3'd4:    return K_PREA;
      3'd5:    return K_REF;
      3'd6:    return K_REF;
      default: return K_MRS_RUN;
    endcase
  endfunction

endpackage

// File: rtl/dinit_upcount.sv
module dinit_upcount #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && (cnt != {W{1'b1}})) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt >= limit);

  // R9
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/dinit_bus_reg.sv
module dinit_bus_reg
  import dinit_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_d,
  input  logic [3:0]        cmd_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              done_d,
  output logic              cke_q,
  output logic [3:0]        cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      cmd_q  <= BUS_DESEL;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  // R2
  cke_low_desel_chk: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (cmd_q == BUS_DESEL));

  // R5
  prea_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == BUS_PRE) |-> (addr_q[10] && ba_q == '0));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cke_q && cmd_q == BUS_NOP));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

endmodule

// File: rtl/ddr_init_sequencer.sv
module ddr_init_sequencer
  import dinit_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned PWR_WAIT_NS   = 200000,
  parameter int unsigned PWR_WAIT_CYC  = (PWR_WAIT_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS,
  parameter int unsigned DLL_LOCK_CYC  = 200,
  parameter int unsigned T_RP          = 3,
  parameter int unsigned T_MRD         = 2,
  parameter int unsigned T_RFC         = 14,
  parameter int unsigned DLL_RST_BIT   = 8,
  parameter int unsigned PRE_ALL_BIT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_stable,
  input  logic [ADDR_W-1:0] mr_value,
  input  logic [ADDR_W-1:0] emr_value,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int unsigned TW = $clog2(PWR_WAIT_CYC + T_RP + T_MRD + T_RFC + 1);
  localparam int unsigned LW = $clog2(DLL_LOCK_CYC + 1);
  localparam logic [ADDR_W-1:0] DLL_RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] PRE_ALL_MASK = ADDR_W'(1) << PRE_ALL_BIT;

  seq_state_e state;
  logic [2:0] idx;
  step_kind_e kind;
  logic       lock_arm;

  logic [TW-1:0] tmr_limit;
  logic          tmr_clr, tmr_en, tmr_hit;
  logic          lock_clr, lock_hit;

  logic              cke_d, done_d;
  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic [3:0]        cmd_q;

  assign kind = step_kind(idx);

  // gap after the command of the current step, in NOP cycles
  always_comb begin
    unique case (kind)
      K_PREA:            tmr_limit = TW'(T_RP - 1);
      K_EMRS, K_MRS_RST,
      K_MRS_RUN:         tmr_limit = TW'(T_MRD - 1);
      K_REF:             tmr_limit = TW'(T_RFC - 1);
      default:           tmr_limit = '0;
    endcase
    if (state == ST_PWR) tmr_limit = TW'(PWR_WAIT_CYC - 1);
  end

  assign tmr_clr  = (state == ST_ISSUE) || (state == ST_PWR && !pwr_stable);
  assign tmr_en   = (state == ST_PWR) || (state == ST_GAP);
  assign lock_clr = (state == ST_ISSUE) && (kind == K_MRS_RST);

  dinit_upcount #(.W(TW)) u_gap_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .limit (tmr_limit),
    .hit   (tmr_hit)
  );

  dinit_upcount #(.W(LW)) u_lock_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (lock_clr),
    .en    (lock_arm),
    .limit (LW'(DLL_LOCK_CYC)),
    .hit   (lock_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PWR;
      idx      <= '0;
      lock_arm <= 1'b0;
    end else begin
      if (lock_clr) lock_arm <= 1'b1;
      unique case (state)
        ST_PWR: if (pwr_stable && tmr_hit) begin
          state <= ST_ISSUE;
          idx   <= '0;
        end
        ST_ISSUE: state <= ST_GAP;
        ST_GAP: if (tmr_hit) begin
          if (idx == LAST_STEP) begin
            state <= ST_LOCK;
          end else begin
            idx   <= idx + 3'd1;
            state <= ST_ISSUE;
          end
        end
        ST_LOCK: if (lock_hit) state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  // command decode for the next bus cycle
  always_comb begin
    cke_d  = (state != ST_PWR);
    cmd_d  = (state == ST_PWR) ? BUS_DESEL : BUS_NOP;
    ba_d   = '0;
    addr_d = '0;
    done_d = (state == ST_DONE);
    if (state == ST_ISSUE) begin
      unique case (kind)
        K_PREA: begin
          cmd_d  = BUS_PRE;
          addr_d = PRE_ALL_MASK;
        end
        K_EMRS: begin
          cmd_d  = BUS_MRS;
          ba_d   = BA_W'(1);
          addr_d = emr_value;
        end
        K_MRS_RST: begin
          cmd_d  = BUS_MRS;
          addr_d = mr_value | DLL_RST_MASK;
        end
        K_MRS_RUN: begin
          cmd_d  = BUS_MRS;
          addr_d = mr_value & ~DLL_RST_MASK;
        end
        K_REF:   cmd_d = BUS_REF;
        default: cmd_d = BUS_NOP;
      endcase
    end
  end

  dinit_bus_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_bus_reg (
    .clk    (clk),
    .rst    (rst),
    .cke_d  (cke_d),
    .cmd_d  (cmd_d),
    .ba_d   (ba_d),
    .addr_d (addr_d),
    .done_d (done_d),
    .cke_q  (mem_cke),
    .cmd_q  (cmd_q),
    .ba_q   (mem_ba),
    .addr_q (mem_addr),
    .done_q (init_done)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;

  // R10
  lock_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> lock_hit);

  // R4
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (idx != $past(idx)) |-> (idx == $past(idx) + 3'd1 || idx == 3'd0));

  // R2
  pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWR && !pwr_stable) |=> (state == ST_PWR));

  // R11
  reset_restart_chk: assert property (@(posedge clk)
    rst |=> (state == ST_PWR && !lock_arm && idx == 3'd0));

endmodule

// File: tb/ddr_init_sequencer_tb.sv
module ddr_init_sequencer_tb;

  localparam int unsigned PWR   = 300;
  localparam int unsigned LOCK  = 200;
  localparam int unsigned TRP   = 3;
  localparam int unsigned TMRD  = 2;
  localparam int unsigned TRFC  = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        pwr_stable;
  logic [12:0] mr_value, emr_value;
  logic        mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
  logic [1:0]  mem_ba;
  logic [12:0] mem_addr;

  always #2.5 clk = ~clk;

  ddr_init_sequencer #(
    .CLK_PERIOD_PS (5000),
    .PWR_WAIT_NS   (1500),
    .DLL_LOCK_CYC  (LOCK),
    .T_RP          (TRP),
    .T_MRD         (TMRD),
    .T_RFC         (TRFC)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .pwr_stable (pwr_stable),
    .mr_value   (mr_value),
    .emr_value  (emr_value),
    .mem_cke    (mem_cke),
    .mem_cs_n   (mem_cs_n),
    .mem_ras_n  (mem_ras_n),
    .mem_cas_n  (mem_cas_n),
    .mem_we_n   (mem_we_n),
    .mem_ba     (mem_ba),
    .mem_addr   (mem_addr),
    .init_done  (init_done)
  );

  // expected run: {strobes[3:0], ba[1:0], addr kind[2:0]}
  // addr kind: 0 zero, 1 bit10, 2 emr, 3 mr|bit8, 4 mr&~bit8
  localparam logic [8:0] EXP [0:6] = '{
    {4'b0010, 2'b00, 3'd1},
    {4'b0000, 2'b01, 3'd2},
    {4'b0000, 2'b00, 3'd3},
    {4'b0010, 2'b00, 3'd1},
    {4'b0001, 2'b00, 3'd0},
    {4'b0001, 2'b00, 3'd0},
    {4'b0000, 2'b00, 3'd4}
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int cyc = 0;
  int trace_n, cke_rise, done_cyc, bad_lo, bad_hi, stable_cyc;
  logic [3:0]  rise_cmd;
  logic [3:0]  t_cmd  [0:15];
  logic [1:0]  t_ba   [0:15];
  logic [12:0] t_addr [0:15];
  int          t_cyc  [0:15];
  logic prev_cke, prev_done;

  wire [3:0] bus = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      trace_n = 0; cke_rise = -1; done_cyc = -1; bad_lo = 0; bad_hi = 0;
      prev_cke = 1'b0; prev_done = 1'b0;
    end else begin
      if (!mem_cke && bus != 4'b1111) bad_lo++;
      if (mem_cke && !prev_cke) begin
        cke_rise = cyc;
        rise_cmd = bus;
      end
      if (mem_cke && bus != 4'b0111 && trace_n < 16) begin
        t_cmd[trace_n] = bus; t_ba[trace_n] = mem_ba;
        t_addr[trace_n] = mem_addr; t_cyc[trace_n] = cyc;
        trace_n++;
      end
      if (init_done && !prev_done) done_cyc = cyc;
      if (init_done && bus != 4'b0111) bad_hi++;
      prev_cke = mem_cke;
      prev_done = init_done;
    end
  end

  function automatic string cmd_req(input logic [3:0] c, input logic [2:0] k);
    if (c == 4'b0010) return "R5";
    if (c == 4'b0001) return "R8";
    if (k == 3'd2) return "R6";
    return "R7";
  endfunction

  function automatic int min_gap(input logic [3:0] c);
    if (c == 4'b0010) return TRP;
    if (c == 4'b0001) return TRFC;
    return TMRD;
  endfunction

  task automatic wait_done();
    for (int i = 0; i < 3000 && !init_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_run(input logic [12:0] mr, input logic [12:0] emr);
    logic [12:0] ea;
    check(cke_rise - stable_cyc >= int'(PWR) && cke_rise - stable_cyc <= int'(PWR) + 2,
          "R2 cke after wait", cke_rise - stable_cyc, PWR);
    check(bad_lo == 0, "R2 deselect while cke low", bad_lo, 0);
    check(rise_cmd == 4'b0111, "R3 nop at cke rise", rise_cmd, 4'b0111);
    check(trace_n == 7, "R4 command count", trace_n, 7);
    for (int i = 0; i < 7; i++) begin
      case (EXP[i][2:0])
        3'd1:    ea = 13'h0400;
        3'd2:    ea = emr;
        3'd3:    ea = mr | 13'h0100;
        3'd4:    ea = mr & ~13'h0100;
        default: ea = 13'h0000;
      endcase
      check(t_cmd[i] == EXP[i][8:5], "R4 order", t_cmd[i], EXP[i][8:5]);
      check(t_ba[i] == EXP[i][4:3], cmd_req(EXP[i][8:5], EXP[i][2:0]), t_ba[i], EXP[i][4:3]);
      check(t_addr[i] == ea, cmd_req(EXP[i][8:5], EXP[i][2:0]), t_addr[i], ea);
      if (i < 6)
        check(t_cyc[i+1] - t_cyc[i] >= min_gap(EXP[i][8:5]) + 1, "R9 gap",
              t_cyc[i+1] - t_cyc[i] - 1, min_gap(EXP[i][8:5]));
    end
    check(done_cyc - t_cyc[2] >= int'(LOCK) && done_cyc - t_cyc[2] <= int'(LOCK) + 4,
          "R10 lock interval", done_cyc - t_cyc[2], LOCK);
    check(done_cyc > t_cyc[6] + int'(TMRD), "R10 after final mode set", done_cyc, t_cyc[6] + TMRD + 1);
  endtask

  task automatic check_idle_state(input string req);
    check(mem_cke == 1'b0, req, mem_cke, 0);
    check(bus == 4'b1111, req, bus, 4'hf);
    check(init_done == 1'b0, req, init_done, 0);
    check(mem_ba == 2'b00 && mem_addr == 13'h0, req, {mem_ba, mem_addr}, 0);
  endtask

  initial begin
    rst = 1'b1; pwr_stable = 1'b0;
    mr_value = 13'h0032; emr_value = 13'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle_state("R1 during reset");
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check_idle_state("R1 after reset");

    // R2: nothing happens without the stable flag
    repeat (40) @(negedge clk);
    check(mem_cke == 1'b0 && bus == 4'b1111, "R2 no stable", {mem_cke, bus}, 5'h0f);

    // R2: flag drops mid-wait, count restarts
    @(posedge clk); #1 pwr_stable = 1'b1;
    repeat (PWR / 2) @(posedge clk);
    #1 pwr_stable = 1'b0;
    repeat (2) @(posedge clk);
    #1 pwr_stable = 1'b1; stable_cyc = cyc;
    wait_done();
    check_run(13'h0032, 13'h0000);

    // R10: done holds with a quiet bus
    repeat (20) @(negedge clk);
    check(init_done == 1'b1 && bad_hi == 0, "R10 done sticky", {init_done, 8'(bad_hi)}, 9'h100);

    // R11: reset after the third command, new mode words, full rerun
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0; stable_cyc = cyc;
    for (int i = 0; i < 2000 && trace_n < 3; i++) @(negedge clk);
    check(trace_n == 3, "R11 reached mid-run", trace_n, 3);
    @(posedge clk); #1 rst = 1'b1;
    mr_value = 13'h0163; emr_value = 13'h0002;
    @(posedge clk); #1 rst = 1'b0; stable_cyc = cyc;
    @(negedge clk);
    check_idle_state("R11 after mid-run reset");
    wait_done();
    check_run(13'h0163, 13'h0002);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule